// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor core that uses overlapping register windows. At any moment the core sees 32 architectural registers of 32 bits. Eight of them are globals that are common to every window. The other 24 are a window of ins, locals and outs, cut out of a larger physical array. The physical array holds the globals plus sixteen registers per window. A window's outs and the ins of the window below it are the same physical registers. A procedure can therefore pass arguments to its callee without copying them.

The block has two combinational read ports and one write port, all addressed by 5-bit architectural numbers. A current window pointer selects the visible window. A window-invalid mask has one bit per window. A SAVE request moves the pointer down one window and a RESTORE request moves it up one, modulo the window count. Before a move, the target window's mask bit is tested. If the bit is set, the pointer stays where it is and a one-cycle overflow pulse (for SAVE) or underflow pulse (for RESTORE) asks trap software to spill or fill a window. Trap entry and return code can load the pointer and the mask directly. The number of windows is a parameter.

Top module: `wreg_window_file`

## Requirements
- R1: Architectural register 0 always reads as zero, and a write to it changes nothing.
- R2: Architectural registers 1 to 7 are globals. They are reached at the same storage whichever window is current.
- R3: A write takes effect at the clock edge. A read of the same register in the same cycle returns the value held before the write.
- R4: When no trap occurs, SAVE sets the pointer to (pointer − 1) mod NWIN and RESTORE sets it to (pointer + 1) mod NWIN, so 0 steps to NWIN−1 and NWIN−1 steps to 0. The new pointer is visible after the edge.
- R5: Registers 8–15 are outs, 16–23 locals and 24–31 ins. Out register 8+i of window w is the same storage as in register 24+i of window (w−1) mod NWIN.
- R6: Locals are private to each window. A local written in one window is not seen in another.
- R7: If the mask bit of window (pointer − 1) mod NWIN is set, SAVE leaves the pointer unchanged. The overflow output is then high for the single cycle after that edge.
- R8: If the mask bit of window (pointer + 1) mod NWIN is set, RESTORE leaves the pointer unchanged. The underflow output is then high for the single cycle after that edge.
- R9: If SAVE and RESTORE are requested in the same cycle, neither takes effect and no trap is raised.
- R10: A direct pointer load takes priority over SAVE and RESTORE in the same cycle and never traps. A load value of NWIN or more is ignored.
- R11: A mask load replaces the whole mask at the edge. Bit w of the mask output is the flag of window w.
- R12: After reset the pointer is 0, the mask is 0, every register reads zero and both trap outputs are low.
- R13: A register write in the same cycle as a SAVE or RESTORE goes to the window that was current before the move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rs1_addr | input | 5 | Read port 1 architectural register |
| rs2_addr | input | 5 | Read port 2 architectural register |
| rs1_data | output | 32 | Read port 1 data (combinational) |
| rs2_data | output | 32 | Read port 2 data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write architectural register |
| wr_data | input | 32 | Write data |
| save_req | input | 1 | Move one window down |
| restore_req | input | 1 | Move one window up |
| cwp_we | input | 1 | Direct pointer load |
| cwp_wdata | input | 5 | Pointer load value |
| wim_we | input | 1 | Mask load |
| wim_wdata | input | NWIN | Mask load value |
| cwp | output | 5 | Current window pointer |
| wim | output | NWIN | Current window-invalid mask |
| trap_overflow | output | 1 | One-cycle pulse: SAVE blocked |
| trap_underflow | output | 1 | One-cycle pulse: RESTORE blocked |

## Verification
Directed sequences cover several cases. Writing an out and then saving shows the out-to-in sharing and sets it apart from a plain window copy. Writing a local and then moving away and back separates private locals from globals. Moves at pointer 0 and at NWIN−1 expose errors in the modulo wrap. Masks that cover only the SAVE target, or only the RESTORE target, show which direction is checked. Simultaneous requests, an out-of-range load, and writes issued in the same cycle as a move test the priorities and the edge timing. Random traffic then mixes reads, writes, moves and mask updates. This catches mapping errors that appear only at particular pointer values.

// File: rtl/wreg_pkg.sv
package wreg_pkg;

    localparam int REG_W  = 5;
    localparam int CWP_W  = 5;
    localparam int GROUP  = 8;

    typedef enum logic [1:0] {
        WOP_NONE,
        WOP_DOWN,
        WOP_UP,
        WOP_LOAD
    } win_op_e;

    typedef struct packed {
        win_op_e          op;
        logic [CWP_W-1:0] load_val;
    } win_req_t;

    typedef struct packed {
        logic             en;
        logic [REG_W-1:0] addr;
        logic [31:0]      data;
    } wr_req_t;

    // Physical index of an architectural register in a given window.
    // Layout: globals 0..7, then per window w a block of 16 at 8+16w:
    // locals first, ins second. Outs of w live in the ins of w-1.
    function automatic int unsigned phys_of(input logic [REG_W-1:0] r,
                                            input logic [CWP_W-1:0] w,
                                            input int unsigned nwin);
        int unsigned wi;
        int unsigned below;
        int unsigned off;
        wi    = 32'(w);
        below = (wi == 0) ? nwin - 1 : wi - 1;
        off   = 32'(r[2:0]);
        case (r[4:3])
            2'd0:    return off;
            2'd1:    return GROUP + 2 * GROUP * below + GROUP + off;
            2'd2:    return GROUP + 2 * GROUP * wi + off;
            default: return GROUP + 2 * GROUP * wi + GROUP + off;
        endcase
    endfunction

endpackage

// File: rtl/wreg_map.sv
module wreg_map
    import wreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int PW   = 8
) (
    input  logic [REG_W-1:0] arch,
    input  logic [CWP_W-1:0] win,
    output logic [PW-1:0]    phys
);
    always_comb begin
        phys = PW'(phys_of(arch, win, NWIN));
    end
endmodule

// File: rtl/wreg_store.sv
module wreg_store #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 136,
    parameter int PW    = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PW-1:0]   ra,
    input  logic [PW-1:0]   rb,
    output logic [XLEN-1:0] qa,
    output logic [XLEN-1:0] qb,
    input  logic            we,
    input  logic [PW-1:0]   wa,
    input  logic [XLEN-1:0] wd
);
    logic [XLEN-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    assign qa = mem[ra];
    assign qb = mem[rb];
endmodule

// File: rtl/wreg_ptrctl.sv
module wreg_ptrctl
    import wreg_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             save_req,
    input  logic             restore_req,
    input  logic             cwp_we,
    input  logic [CWP_W-1:0] cwp_wdata,
    input  logic             wim_we,
    input  logic [NWIN-1:0]  wim_wdata,
    output logic [CWP_W-1:0] cwp_q,
    output logic [NWIN-1:0]  wim_q,
    output logic             ovf_q,
    output logic             unf_q
);
    localparam logic [CWP_W-1:0] TOP = CWP_W'(NWIN - 1);

    win_req_t         req;
    logic [CWP_W-1:0] down_w, up_w;
    logic [NWIN-1:0]  down_sh, up_sh;
    logic             down_bad, up_bad;

    always_comb begin
        req.load_val = cwp_wdata;
        if (cwp_we)                         req.op = WOP_LOAD;
        else if (save_req && !restore_req)  req.op = WOP_DOWN;
        else if (restore_req && !save_req)  req.op = WOP_UP;
        else                                req.op = WOP_NONE;

        down_w   = (cwp_q == '0)  ? TOP : cwp_q - 1'b1;
        up_w     = (cwp_q == TOP) ? '0  : cwp_q + 1'b1;
        down_sh  = wim_q >> down_w;
        up_sh    = wim_q >> up_w;
        down_bad = down_sh[0];
        up_bad   = up_sh[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp_q <= '0;
            wim_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            if (wim_we) wim_q <= wim_wdata;
            case (req.op)
                WOP_LOAD: if (int'(req.load_val) < NWIN) cwp_q <= req.load_val;
                WOP_DOWN: if (down_bad) ovf_q <= 1'b1; else cwp_q <= down_w;
                WOP_UP:   if (up_bad)   unf_q <= 1'b1; else cwp_q <= up_w;
                default:  ;
            endcase
        end
    end

    a_r4_cwp_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(cwp_q) < NWIN);

    a_r4_save_steps_down: assert property (@(posedge clk) disable iff (rst)
        (save_req && !restore_req && !cwp_we) |=>
        (ovf_q || cwp_q == (($past(cwp_q) == '0) ? TOP : $past(cwp_q) - 1'b1)));

    a_r7_overflow_holds_cwp: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> cwp_q == $past(cwp_q));

    a_r8_underflow_holds_cwp: assert property (@(posedge clk) disable iff (rst)
        unf_q |-> cwp_q == $past(cwp_q));

    a_r7_traps_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ovf_q && unf_q));

    a_r9_conflict_no_move: assert property (@(posedge clk) disable iff (rst)
        (save_req && restore_req && !cwp_we) |=> ($stable(cwp_q) && !ovf_q && !unf_q));
endmodule

// File: rtl/wreg_window_file.sv
module wreg_window_file
    import wreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [4:0]       rs1_addr,
    input  logic [4:0]       rs2_addr,
    output logic [XLEN-1:0]  rs1_data,
    output logic [XLEN-1:0]  rs2_data,
    input  logic             wr_en,
    input  logic [4:0]       wr_addr,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             save_req,
    input  logic             restore_req,
    input  logic             cwp_we,
    input  logic [4:0]       cwp_wdata,
    input  logic             wim_we,
    input  logic [NWIN-1:0]  wim_wdata,
    output logic [4:0]       cwp,
    output logic [NWIN-1:0]  wim,
    output logic             trap_overflow,
    output logic             trap_underflow
);
    localparam int DEPTH = GROUP + 2 * GROUP * NWIN;
    localparam int PW    = $clog2(DEPTH);
    localparam int NPORT = 3;

    logic [NPORT-1:0][REG_W-1:0] arch_a;
    logic [NPORT-1:0][PW-1:0]    phys_a;
    logic                        wr_live;

    assign arch_a[0] = rs1_addr;
    assign arch_a[1] = rs2_addr;
    assign arch_a[2] = wr_addr;
    assign wr_live   = wr_en && (wr_addr != '0);

    wreg_ptrctl #(.NWIN(NWIN)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .save_req   (save_req),
        .restore_req(restore_req),
        .cwp_we     (cwp_we),
        .cwp_wdata  (cwp_wdata),
        .wim_we     (wim_we),
        .wim_wdata  (wim_wdata),
        .cwp_q      (cwp),
        .wim_q      (wim),
        .ovf_q      (trap_overflow),
        .unf_q      (trap_underflow)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        wreg_map #(.NWIN(NWIN), .PW(PW)) u_map (
            .arch(arch_a[p]),
            .win (cwp),
            .phys(phys_a[p])
        );
    end

    wreg_store #(.XLEN(XLEN), .DEPTH(DEPTH), .PW(PW)) u_store (
        .clk(clk),
        .rst(rst),
        .ra (phys_a[0]),
        .rb (phys_a[1]),
        .qa (rs1_data),
        .qb (rs2_data),
        .we (wr_live),
        .wa (phys_a[2]),
        .wd (wr_data)
    );

    a_r1_zero_port1: assert property (@(posedge clk) disable iff (rst)
        (rs1_addr == '0) |-> (rs1_data == '0));

    a_r1_zero_port2: assert property (@(posedge clk) disable iff (rst)
        (rs2_addr == '0) |-> (rs2_data == '0));
endmodule

// File: tb/wreg_window_file_bench.sv
`timescale 1ns/1ps
module wreg_window_file_bench;
    localparam int NW = 8;

    logic          clk = 0;
    logic          rst = 1;
    logic [4:0]    rs1_addr, rs2_addr, wr_addr, cwp_wdata;
    logic [31:0]   rs1_data, rs2_data, wr_data;
    logic          wr_en, save_req, restore_req, cwp_we, wim_we;
    logic [NW-1:0] wim_wdata, wim;
    logic [4:0]    cwp;
    logic          trap_overflow, trap_underflow;

    always #2.5 clk = ~clk;

    wreg_window_file #(.NWIN(NW), .XLEN(32)) u_wreg_window_file (.*);

    int total = 0, bad = 0;
    bit finished = 0;

    // Reference state built from the requirements
    logic [31:0]   glob [8];
    logic [31:0]   loc  [NW][8];
    logic [31:0]   ins  [NW][8];
    int            mcwp = 0;
    logic [NW-1:0] mwim = '0;
    logic          exp_ovf = 0, exp_unf = 0;

    function automatic logic [31:0] mread(input logic [4:0] r);
        int i;
        i = int'(r[2:0]);
        if (r == 0)       return 32'h0;
        else if (r < 8)   return glob[i];
        else if (r < 16)  return ins[(mcwp + NW - 1) % NW][i];
        else if (r < 24)  return loc[mcwp][i];
        else              return ins[mcwp][i];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clr();
        wr_en = 0; wr_addr = 0; wr_data = 0; rs1_addr = 0; rs2_addr = 0;
        save_req = 0; restore_req = 0; cwp_we = 0; cwp_wdata = 0;
        wim_we = 0; wim_wdata = '0;
    endtask

    // Called just after a falling edge with inputs driven; checks the
    // current outputs, then advances the reference across the next edge.
    task automatic tick(input string tag);
        int i, tgt;
        #1;
        chk(tag, rs1_data, mread(rs1_addr));
        chk(tag, rs2_data, mread(rs2_addr));
        chk(tag, 32'(cwp), 32'(mcwp));
        chk("R11", 32'(wim), 32'(mwim));
        chk("R7", 32'(trap_overflow), 32'(exp_ovf));
        chk("R8", 32'(trap_underflow), 32'(exp_unf));
        // R13: write goes to the window current before any move
        if (wr_en && wr_addr != 0) begin
            i = int'(wr_addr[2:0]);
            if (wr_addr < 8)       glob[i] = wr_data;
            else if (wr_addr < 16) ins[(mcwp + NW - 1) % NW][i] = wr_data;
            else if (wr_addr < 24) loc[mcwp][i] = wr_data;
            else                   ins[mcwp][i] = wr_data;
        end
        exp_ovf = 0; exp_unf = 0;
        if (cwp_we) begin
            if (int'(cwp_wdata) < NW) mcwp = int'(cwp_wdata);
        end else if (save_req && !restore_req) begin
            tgt = (mcwp + NW - 1) % NW;
            if (mwim[tgt]) exp_ovf = 1; else mcwp = tgt;
        end else if (restore_req && !save_req) begin
            tgt = (mcwp + 1) % NW;
            if (mwim[tgt]) exp_unf = 1; else mcwp = tgt;
        end
        if (wim_we) mwim = wim_wdata;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        for (int g = 0; g < 8; g++) glob[g] = 0;
        for (int w = 0; w < NW; w++)
            for (int k = 0; k < 8; k++) begin loc[w][k] = 0; ins[w][k] = 0; end
        clr();
        repeat (3) @(negedge clk);
        rst = 0;

        // R12: reset state
        rs1_addr = 5; rs2_addr = 30; tick("R12");
        // R1: writes to register 0 discarded
        clr(); wr_en = 1; wr_addr = 0; wr_data = 32'hDEAD_BEEF; tick("R1");
        clr(); rs1_addr = 0; rs2_addr = 0; tick("R1");
        // R3: same-cycle read returns the old value
        clr(); wr_en = 1; wr_addr = 3; wr_data = 32'hA0A0_0003; rs1_addr = 3; tick("R3");
        clr(); rs1_addr = 3; tick("R3");
        clr(); wr_en = 1; wr_addr = 20; wr_data = 32'hB0B0_0014; tick("R6");
        clr(); wr_en = 1; wr_addr = 10; wr_data = 32'hC0C0_000A; tick("R5");
        // R4: save from 0 wraps to NW-1
        clr(); save_req = 1; tick("R4");
        clr(); rs1_addr = 3; rs2_addr = 26; tick("R2");   // global kept, out became in
        clr(); rs1_addr = 20; rs2_addr = 10; tick("R6");  // fresh locals
        // R13: write in a save cycle lands in the old window
        clr(); wr_en = 1; wr_addr = 12; wr_data = 32'hD0D0_000C; save_req = 1; tick("R13");
        clr(); rs1_addr = 28; rs2_addr = 12; tick("R13");
        clr(); restore_req = 1; tick("R4");
        clr(); restore_req = 1; tick("R4");
        clr(); rs1_addr = 20; rs2_addr = 10; tick("R6");
        // R10: direct load, wrap on restore, out-of-range load ignored
        clr(); cwp_we = 1; cwp_wdata = 5'd7; tick("R10");
        clr(); restore_req = 1; tick("R4");
        clr(); cwp_we = 1; cwp_wdata = 5'd9; tick("R10");
        clr(); tick("R10");
        // R7: overflow
        clr(); wim_we = 1; wim_wdata = 8'h80; tick("R11");
        clr(); save_req = 1; tick("R7");
        clr(); tick("R7");
        clr(); tick("R7");
        // R8: underflow
        clr(); wim_we = 1; wim_wdata = 8'h02; tick("R11");
        clr(); restore_req = 1; tick("R8");
        clr(); tick("R8");
        clr(); tick("R8");
        // R9: conflicting requests
        clr(); wim_we = 1; wim_wdata = 8'h00; tick("R11");
        clr(); save_req = 1; restore_req = 1; tick("R9");
        clr(); tick("R9");
        // R10: load beats save
        clr(); cwp_we = 1; cwp_wdata = 5'd3; save_req = 1; tick("R10");
        clr(); tick("R10");

        // Random phase
        seed = $urandom(32'd20240611);
        for (int n = 0; n < 4000; n++) begin
            int pick;
            clr();
            rs1_addr = 5'($urandom);
            rs2_addr = 5'($urandom);
            wr_en    = ($urandom % 10) < 6;
            wr_addr  = 5'($urandom);
            wr_data  = $urandom;
            pick     = int'($urandom % 100);
            if (pick < 12)       save_req = 1;
            else if (pick < 24)  restore_req = 1;
            else if (pick < 26)  begin save_req = 1; restore_req = 1; end
            else if (pick < 28)  begin cwp_we = 1; cwp_wdata = 5'($urandom); end
            if (($urandom % 100) < 4) begin wim_we = 1; wim_wdata = NW'($urandom) & NW'($urandom); end
            tick("R5 R4 random");
        end
        clr(); tick("R5 R4 random");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule